// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be kept. It takes the first four identifier bytes of the frame, compares them with eight programmable code bytes, and uses eight matching mask bytes to say which bit positions count. The code and mask bytes form two banks of four. A mode input chooses how the banks are used. In one mode they act as two wide filters of 32 bits. In the other they act as four narrow filters of 16 bits.

Software programs the code and mask bytes through a simple register port. Reads are allowed at any time. Writes are accepted only while the controller is in initialization, which means both the init request and the init acknowledge are high. The receive path presents the identifier bytes together with a one-cycle strobe. One clock later the block returns an accept flag and the number of the filter that matched.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, every code byte and every mask byte reads 0x00, and `accept` and `hit_idx` are 0.
- R2: `reg_rdata` shows the addressed byte combinationally at any time. `reg_addr[3]`=0 selects a code byte and `reg_addr[3]`=1 selects a mask byte. `reg_addr[2:0]` is the byte number from 0 to 7.
- R3: A write with `reg_we`=1 changes the addressed byte only when `init_req` and `init_ack` are both 1. Any other write leaves every byte unchanged.
- R4: A mask bit of 0 requires the identifier bit to equal the code bit. A mask bit of 1 removes that bit from the comparison.
- R5: With `mode_16`=0 there are two filters. Filter 0 compares code/mask bytes 0–3 with identifier bytes 0–3, and filter 1 compares bytes 4–7 with identifier bytes 0–3. Identifier byte n sits in `id_bytes[8n+7:8n]`.
- R6: With `mode_16`=1 there are four filters. Filter k compares code/mask bytes 2k and 2k+1 with identifier bytes 0 and 1. Identifier bytes 2 and 3 have no effect in this mode.
- R7: `accept` is 1 when any active filter matches. `hit_idx` gives the lowest-numbered matching filter. Both outputs are 0 when no filter matches.
- R8: `accept` and `hit_idx` update on the clock edge that samples `id_valid`=1. They hold their values on every edge where `id_valid` is 0.
- R9: To accept standard identifiers, mask bits [2:0] of byte 1 are set (and of byte 5, plus bytes 3 and 7 in 16-bit mode). An identifier that differs from the code only in byte 1 bits [2:0] is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Initialization requested |
| init_ack | input | 1 | Initialization acknowledged |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 selects mask or code; bits 2:0 select the byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte |
| mode_16 | input | 1 | 0: two 32-bit filters; 1: four 16-bit filters |
| id_valid | input | 1 | Identifier strobe |
| id_bytes | input | 32 | Identifier bytes 0–3, byte 0 in the low bits |
| accept | output | 1 | Frame accepted |
| hit_idx | output | 2 | Lowest-numbered matching filter |

## Verification
A register read is combinational, so the bench checks `reg_rdata` shortly after it sets the address on a falling edge. A write reaches the registers on the next rising edge. The filter result is due on the rising edge that samples the strobe. The driver raises `id_valid` on a falling edge and queues the expected result. The monitor records at each rising edge whether a strobe was sampled, and on the following falling edge it compares the outputs with the head of the queue. Hold behaviour is checked by sampling the outputs over several idle cycles after a result, while the identifier and mode inputs change.

// File: rtl/acf_pkg.sv
// Package: shared sizing constants for the acceptance filter.
// Assumes byte-wide registers and a fixed two-bank layout.
package acf_pkg;
    localparam int ACF_BYTE_W   = 8;
    localparam int ACF_NBYTES   = 8;
    localparam int ACF_ID_BYTES = ACF_NBYTES / 2;
    localparam int ACF_NFILT    = ACF_NBYTES / 2;
endpackage

// File: rtl/acf_regs.sv
// Module: code and mask register file.
// Holds NBYTES code bytes and NBYTES mask bytes, all reset to zero.
// Read is combinational; the write enable arrives already gated.
module acf_regs #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 8,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W:0]           addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    output logic [NBYTES*BYTE_W-1:0] code_o,
    output logic [NBYTES*BYTE_W-1:0] mask_o
);
    logic [BYTE_W-1:0] code_r [NBYTES];
    logic [BYTE_W-1:0] mask_r [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Update one code byte and one mask byte on a write to that address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_r[i] <= '0;
                mask_r[i] <= '0;
            end else if (wr_en && addr[IDX_W-1:0] == IDX_W'(i)) begin
                if (addr[IDX_W]) mask_r[i] <= wdata;
                else             code_r[i] <= wdata;
            end
        end
        assign code_o[i*BYTE_W +: BYTE_W] = code_r[i];
        assign mask_o[i*BYTE_W +: BYTE_W] = mask_r[i];
    end

    // Select the addressed byte for readback.
    always_comb begin
        if (addr[IDX_W]) rdata = mask_r[addr[IDX_W-1:0]];
        else             rdata = code_r[addr[IDX_W-1:0]];
    end
endmodule

// File: rtl/acf_match.sv
// Module: per-byte masked compare and grouping into filters.
// Assumes NBYTES is 8: two banks of four bytes, or four pairs of bytes.
// A mask bit of 1 removes that bit from the compare.
module acf_match #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 8,
    localparam int NFILT = NBYTES / 2,
    localparam int NID   = NBYTES / 2
) (
    input  logic [NBYTES*BYTE_W-1:0] code_i,
    input  logic [NBYTES*BYTE_W-1:0] mask_i,
    input  logic [NID*BYTE_W-1:0]    id_i,
    input  logic                     mode16_i,
    output logic [NFILT-1:0]         hits_o
);
    logic [NBYTES-1:0]  byte_ok;
    logic [NFILT-1:0]   wide_hit;
    logic [NFILT-1:0]   narrow_hit;

    for (genvar i = 0; i < NBYTES; i++) begin : g_cmp
        logic [BYTE_W-1:0] id_sel;
        // Pick the identifier byte this code byte faces in the current mode.
        always_comb begin
            if (mode16_i) id_sel = id_i[(i % 2)*BYTE_W +: BYTE_W];
            else          id_sel = id_i[(i % 4)*BYTE_W +: BYTE_W];
        end
        assign byte_ok[i] = &(~(code_i[i*BYTE_W +: BYTE_W] ^ id_sel)
                              | mask_i[i*BYTE_W +: BYTE_W]);
    end

    for (genvar k = 0; k < NFILT; k++) begin : g_filt
        if (k < NBYTES / 4) begin : g_wide
            assign wide_hit[k] = &byte_ok[4*k +: 4];
        end else begin : g_nowide
            assign wide_hit[k] = 1'b0;
        end
        assign narrow_hit[k] = &byte_ok[2*k +: 2];
    end

    assign hits_o = mode16_i ? narrow_hit : wide_hit;
endmodule

// File: rtl/acf_pick.sv
// Module: priority pick of the lowest-numbered matching filter.
// Returns zero for the index when no filter matches.
module acf_pick #(
    parameter int NFILT = 4,
    localparam int FW   = $clog2(NFILT)
) (
    input  logic [NFILT-1:0] hits_i,
    output logic             any_o,
    output logic [FW-1:0]    idx_o
);
    // Walk from the highest filter down so the lowest match wins.
    always_comb begin
        idx_o = '0;
        for (int k = NFILT - 1; k >= 0; k--) begin
            if (hits_i[k]) idx_o = FW'(k);
        end
    end
    assign any_o = |hits_i;
endmodule

// File: rtl/can_accept_filter.sv
// Module: CAN identifier acceptance filter top.
// Gates register writes with the init handshake and runs the compare.
// Registers accept and the hit index on each identifier strobe.
module can_accept_filter #(
    parameter int BYTE_W = acf_pkg::ACF_BYTE_W,
    parameter int NBYTES = acf_pkg::ACF_NBYTES,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int NFILT = NBYTES / 2,
    localparam int NID   = NBYTES / 2,
    localparam int FW    = $clog2(NFILT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_req,
    input  logic                  init_ack,
    input  logic                  reg_we,
    input  logic [IDX_W:0]        reg_addr,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     reg_rdata,
    input  logic                  mode_16,
    input  logic                  id_valid,
    input  logic [NID*BYTE_W-1:0] id_bytes,
    output logic                  accept,
    output logic [FW-1:0]         hit_idx
);
    logic                     wr_ok;
    logic [NBYTES*BYTE_W-1:0] code_q;
    logic [NBYTES*BYTE_W-1:0] mask_q;
    logic [NFILT-1:0]         hits;
    logic                     any_hit;
    logic [FW-1:0]            pick_idx;

    assign wr_ok = reg_we && init_req && init_ack;

    acf_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .code_o(code_q), .mask_o(mask_q)
    );

    acf_match #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_match (
        .code_i(code_q), .mask_i(mask_q), .id_i(id_bytes),
        .mode16_i(mode_16), .hits_o(hits)
    );

    acf_pick #(.NFILT(NFILT)) u_pick (
        .hits_i(hits), .any_o(any_hit), .idx_o(pick_idx)
    );

    // Capture the decision on the strobe edge and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            hit_idx <= '0;
        end else if (id_valid) begin
            accept  <= any_hit;
            hit_idx <= any_hit ? pick_idx : '0;
        end
    end
endmodule

// File: rtl/acf_checker.sv
// Module: property checker for the acceptance filter, bound to the top.
// Assumes the default sizing: eight bytes and four filter slots.
module acf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        init_req,
    input logic        init_ack,
    input logic        id_valid,
    input logic        mode_16,
    input logic        accept,
    input logic [1:0]  hit_idx,
    input logic [63:0] code_q,
    input logic [63:0] mask_q
);
    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_req && init_ack) |=> ($stable(code_q) && $stable(mask_q))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> ($stable(accept) && $stable(hit_idx))); // R8
    AST_IDX_ZERO_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> hit_idx == 2'd0); // R7
    AST_WIDE_TWO_FILTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !mode_16) |=> !hit_idx[1]); // R5
    AST_ALL_IGNORED_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && (&mask_q)) |=> (accept && hit_idx == 2'd0)); // R4
endmodule

bind can_accept_filter acf_checker u_acf_checker (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .id_valid(id_valid), .mode_16(mode_16), .accept(accept),
    .hit_idx(hit_idx), .code_q(code_q), .mask_q(mask_q)
);

// File: tb/can_accept_filter_bench.sv
// Bench: scoreboard test of the acceptance filter.
// The driver queues expected decisions; the monitor compares them.
module can_accept_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, init_ack = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mode_16 = 1'b0, id_valid = 1'b0;
    logic [31:0] id_bytes = '0;
    logic        accept;
    logic [1:0]  hit_idx;

    int checks = 0, fails = 0;
    logic [7:0] mc [8];
    logic [7:0] mm [8];
    logic [2:0] expq [$];
    string      tagq [$];
    logic       pend = 1'b0;

    always #2.5 clk = ~clk;

    can_accept_filter u_can_accept_filter (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode_16(mode_16), .id_valid(id_valid),
        .id_bytes(id_bytes), .accept(accept), .hit_idx(hit_idx)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference decision: {accept, index} from the requirement text.
    function automatic logic [2:0] model(input logic [31:0] id, input logic m16);
        logic [3:0] fh;
        logic [2:0] r;
        fh = '0;
        for (int k = 0; k < 4; k++) begin
            if (m16) begin
                fh[k] = 1'b1;
                for (int b = 0; b < 2; b++)
                    if (((mc[2*k+b] ^ id[8*b +: 8]) & ~mm[2*k+b]) != 0) fh[k] = 1'b0;
            end else if (k < 2) begin
                fh[k] = 1'b1;
                for (int b = 0; b < 4; b++)
                    if (((mc[4*k+b] ^ id[8*b +: 8]) & ~mm[4*k+b]) != 0) fh[k] = 1'b0;
            end
        end
        r = 3'b000;
        for (int k = 3; k >= 0; k--) if (fh[k]) r = {1'b1, 2'(k)};
        return r;
    endfunction

    task automatic wr(input logic msk, input int idx, input logic [7:0] d);
        @(negedge clk);
        reg_addr = {msk, 3'(idx)}; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (init_req && init_ack) begin
            if (msk) mm[idx] = d; else mc[idx] = d;
        end
    endtask

    task automatic rd(input string req, input logic msk, input int idx, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = {msk, 3'(idx)};
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic send(input string req, input logic m16, input logic [31:0] id,
                        input logic [2:0] exp);
        @(negedge clk);
        mode_16 = m16; id_bytes = id; id_valid = 1'b1;
        check({req, " model"}, {5'd0, model(id, m16)}, {5'd0, exp});
        expq.push_back(exp); tagq.push_back(req);
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    // Monitor: note strobes at the edge, compare results at the next falling edge.
    always @(posedge clk) pend <= id_valid;
    always @(negedge clk) begin
        if (pend && rst_n) begin
            if (expq.size() == 0) check("R8 unexpected", 8'd1, 8'd0);
            else begin
                logic [2:0] e;
                string t;
                e = expq.pop_front(); t = tagq.pop_front();
                check(t, {5'd0, accept, hit_idx}, {5'd0, e});
            end
        end
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mc[i] = 8'h00; mm[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int i = 0; i < 8; i++) begin rd("R1 code", 1'b0, i, 8'h00); rd("R1 mask", 1'b1, i, 8'h00); end
        check("R1 accept", {7'd0, accept}, 8'd0);
        check("R1 hit_idx", {6'd0, hit_idx}, 8'd0);
        // R3: writes blocked without the full handshake
        init_req = 1'b1; init_ack = 1'b0;
        wr(1'b0, 0, 8'h55);
        rd("R3 req only", 1'b0, 0, 8'h00);
        init_req = 1'b0; init_ack = 1'b1;
        wr(1'b1, 2, 8'hAA);
        rd("R3 ack only", 1'b1, 2, 8'h00);
        // R2: program in init mode and read back
        init_req = 1'b1; init_ack = 1'b1;
        wr(1'b0, 0, 8'h12); wr(1'b0, 1, 8'h34); wr(1'b0, 2, 8'h56); wr(1'b0, 3, 8'h78);
        wr(1'b0, 4, 8'hF0); wr(1'b0, 5, 8'h0F); wr(1'b0, 6, 8'hC3); wr(1'b0, 7, 8'h3C);
        rd("R2 code0", 1'b0, 0, 8'h12);
        rd("R2 code7", 1'b0, 7, 8'h3C);
        rd("R2 mask0", 1'b1, 0, 8'h00);
        init_req = 1'b0;
        wr(1'b0, 3, 8'hEE);
        rd("R3 locked again", 1'b0, 3, 8'h78);
        // R4/R5: exact match on bank 0, mismatch, then masked bit
        send("R5 bank0 exact", 1'b0, 32'h78563412, 3'b100);
        send("R4 one bit off", 1'b0, 32'h78563413, 3'b000);
        send("R5 bank1 exact", 1'b0, 32'h3CC30FF0, 3'b101);
        init_req = 1'b1;
        wr(1'b1, 0, 8'h01);
        send("R4 masked bit ignored", 1'b0, 32'h78563413, 3'b100);
        // R9: standard identifier don't-care bits in 32-bit mode
        wr(1'b1, 1, 8'h07); wr(1'b1, 5, 8'h07);
        send("R9 std 32 bank0", 1'b0, 32'h78563612, 3'b100);
        send("R9 std 32 bank1", 1'b0, 32'h3CC30AF0, 3'b101);
        send("R9 bit3 still checked", 1'b0, 32'h78563C12, 3'b000);
        // R6/R7: 16-bit mode, priority and ignored upper bytes
        wr(1'b0, 2, 8'h12); wr(1'b0, 3, 8'h34);
        wr(1'b1, 3, 8'h07); wr(1'b1, 7, 8'h07);
        send("R7 lowest of 0 and 1", 1'b1, 32'hDEAD3412, 3'b100);
        wr(1'b0, 0, 8'h99);
        send("R7 filter1 only", 1'b1, 32'h00003412, 3'b101);
        wr(1'b0, 4, 8'h12); wr(1'b0, 5, 8'h34);
        send("R7 lowest of 1 and 2", 1'b1, 32'hFFFF3512, 3'b101);
        send("R6 filter3", 1'b1, 32'h12343CC3, 3'b111);
        send("R7 none", 1'b1, 32'h00000000, 3'b000);
        // R8: outputs hold with no strobe
        send("R8 set", 1'b1, 32'h00003412, 3'b101);
        @(negedge clk); id_bytes = 32'h0; mode_16 = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hold accept", {7'd0, accept}, 8'd1);
        check("R8 hold idx", {6'd0, hit_idx}, 8'd1);
        repeat (2) @(negedge clk);
        check("R8 queue drained", 8'(expq.size()), 8'd0);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule